// File: doc/BRIEF.md
# Ternary Full Adder

This block adds three ternary digits (trits), two operands and an incoming carry, and returns a sum trit and a carry trit. It is purely combinational. Each trit travels on two binary wires: `2'b00` is 0, `2'b01` is 1 and `2'b10` is 2. The fourth pattern is not a trit. It raises an error flag.

The internal structure is fixed. Only the first operand is turned into binary flags. A first row of 3:1 multiplexers, steered by the second operand, forms active-low indicator signals. Three shared sum indicators serve all three carry-in values, because the per-carry-in indicator pairs are rotations of one another. Small encoders then turn each indicator pair into a candidate trit, one candidate per carry-in value. A last 3:1 multiplexer, steered by the carry-in, selects the candidate. The block is meant to be replicated to build ripple adders and subtractors on trit vectors.

Top module: `ternary_full_adder`

## Requirements
- R1: For every legal combination of `a_trit`, `b_trit` and `cin_trit`, the values satisfy sum + 3*carry = a + b + cin.
- R2: Trits use the codes 2'b00 = 0, 2'b01 = 1 and 2'b10 = 2. The outputs `sum_trit` and `carry_trit` never carry the code 2'b11.
- R3: If any input carries the code 2'b11, `code_err` is 1 and both `sum_trit` and `carry_trit` are 2'b00.
- R4: `code_err` is 0 whenever all three inputs carry legal codes.
- R5: For legal operands, exactly one of the three shared active-low sum indicators is low.
- R6: When the carry-in is 2, the two carry indicators (carry 1 and carry 2) are never active together.
- R7: The operand decoder keeps its flags consistent. The zero flag implies the low-range flag (operand 0 or 1). The middle flag is active (low) only when the low-range flag is set and the zero flag is clear.
- R8: The carry output is 2 only for the input 2 + 2 + 2, which gives sum 0.
- R9: Swapping `a_trit` and `b_trit` leaves both outputs unchanged, even though only `a_trit` is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_trit | input | 2 | First operand trit, the only one decoded to binary flags |
| b_trit | input | 2 | Second operand trit, steers the first multiplexer row |
| cin_trit | input | 2 | Carry-in trit, steers the final multiplexer |
| sum_trit | output | 2 | Sum trit |
| carry_trit | output | 2 | Carry-out trit |
| code_err | output | 1 | High when any input carries the illegal code 2'b11 |

## Verification
The hardest condition to reach from the ports is a carry-out of 2. Only one of the 27 legal combinations produces it, and it is the only case where the Cin=2 carry encoder gives priority to its carry-2 input. The stimulus walks the whole 27-entry operand space in one table, so that this case and every rotation of the shared sum indicators are each hit. Directed vectors then place the illegal code on each input in turn, and apply every operand pair in both orders.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  localparam int TRIT_W = 2;
  typedef logic [TRIT_W-1:0] trit_t;

  localparam trit_t T0  = 2'b00;
  localparam trit_t T1  = 2'b01;
  localparam trit_t T2  = 2'b10;
  localparam trit_t TBAD = 2'b11;

  // number of shared sum indicators and of carry indicators
  localparam int N_SUM_IND = 3;
  localparam int N_CRY_IND = 4;

  function automatic int trit_val(input trit_t t);
    case (t)
      T1:      return 1;
      T2:      return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic trit_bad(input trit_t t);
    return t == TBAD;
  endfunction

  // which shared indicator marks sum=1 / sum=2 for a given carry-in value
  function automatic int one_sel(input int cin);
    return (3 - cin) % 3;
  endfunction

  function automatic int two_sel(input int cin);
    return (4 - cin) % 3;
  endfunction
endpackage

// File: rtl/tfa_decode.sv
module tfa_decode
  import tfa_pkg::*;
(
  input  trit_t op,
  output logic  is_zero,
  output logic  is_low,
  output logic  mid_n
);
  always_comb begin
    is_zero = (op == T0);
    is_low  = (op == T0) || (op == T1);
    mid_n   = ~(is_low & ~is_zero);
    // R7
    dec_order_chk: assert (!is_zero || is_low)
      else $error("decoder: zero flag without low-range flag");
    // R7
    dec_mid_chk: assert (mid_n || (is_low && !is_zero))
      else $error("decoder: middle flag active outside range");
  end
endmodule

// File: rtl/tfa_mux3.sv
module tfa_mux3
  import tfa_pkg::*;
#(
  parameter int W = 1
) (
  input  trit_t        sel,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  input  logic [W-1:0] d2,
  output logic [W-1:0] y
);
  always_comb begin
    case (sel)
      T0:      y = d0;
      T1:      y = d1;
      T2:      y = d2;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/tfa_enc.sv
module tfa_enc
  import tfa_pkg::*;
#(
  parameter bit TWO_LEVEL = 1'b1
) (
  input  logic  one_n,
  input  logic  two_n,
  output trit_t y
);
  generate
    if (TWO_LEVEL) begin : g_two
      always_comb begin
        if (!two_n)      y = T2;
        else if (!one_n) y = T1;
        else             y = T0;
      end
    end else begin : g_one
      logic unused_two;
      assign unused_two = two_n;
      always_comb y = one_n ? T0 : T1;
    end
  endgenerate
endmodule

// File: rtl/ternary_full_adder.sv
module ternary_full_adder
  import tfa_pkg::*;
(
  input  logic [1:0] a_trit,
  input  logic [1:0] b_trit,
  input  logic [1:0] cin_trit,
  output logic [1:0] sum_trit,
  output logic [1:0] carry_trit,
  output logic       code_err
);
  logic is_zero, is_low, mid_n;

  tfa_decode u_dec (
    .op      (a_trit),
    .is_zero (is_zero),
    .is_low  (is_low),
    .mid_n   (mid_n)
  );

  // shared active-low sum indicators, index 0/1/2
  logic [N_SUM_IND-1:0] sum_ind_n;
  tfa_mux3 #(.W(N_SUM_IND)) u_sum_mux (
    .sel (b_trit),
    .d0  ({~is_zero, is_low, mid_n}),
    .d1  ({is_low, mid_n, ~is_zero}),
    .d2  ({mid_n, ~is_zero, is_low}),
    .y   (sum_ind_n)
  );

  // carry indicators: [0] cin0, [1] cin1, [2] cin2 carry1, [3] cin2 carry2
  logic [N_CRY_IND-1:0] cry_ind_n;
  tfa_mux3 #(.W(N_CRY_IND)) u_cry_mux (
    .sel (b_trit),
    .d0  ({1'b1, is_zero, is_low, 1'b1}),
    .d1  ({1'b1, 1'b0, is_zero, is_low}),
    .d2  ({is_low, ~is_low, 1'b0, is_zero}),
    .y   (cry_ind_n)
  );

  trit_t sum_part [3];
  trit_t cry_part [3];

  generate
    for (genvar k = 0; k < 3; k++) begin : g_cin
      localparam int ONE_IX = one_sel(k);
      localparam int TWO_IX = two_sel(k);
      tfa_enc #(.TWO_LEVEL(1'b1)) u_sum_enc (
        .one_n (sum_ind_n[ONE_IX]),
        .two_n (sum_ind_n[TWO_IX]),
        .y     (sum_part[k])
      );
      if (k < 2) begin : g_c1
        tfa_enc #(.TWO_LEVEL(1'b0)) u_cry_enc (
          .one_n (cry_ind_n[k]),
          .two_n (1'b1),
          .y     (cry_part[k])
        );
      end else begin : g_c2
        tfa_enc #(.TWO_LEVEL(1'b1)) u_cry_enc (
          .one_n (cry_ind_n[2]),
          .two_n (cry_ind_n[3]),
          .y     (cry_part[k])
        );
      end
    end
  endgenerate

  logic [2*TRIT_W-1:0] picked;
  tfa_mux3 #(.W(2*TRIT_W)) u_fin_mux (
    .sel (cin_trit),
    .d0  ({cry_part[0], sum_part[0]}),
    .d1  ({cry_part[1], sum_part[1]}),
    .d2  ({cry_part[2], sum_part[2]}),
    .y   (picked)
  );

  always_comb begin
    code_err   = trit_bad(a_trit) | trit_bad(b_trit) | trit_bad(cin_trit);
    sum_trit   = code_err ? T0 : picked[TRIT_W-1:0];
    carry_trit = code_err ? T0 : picked[2*TRIT_W-1:TRIT_W];
  end

  always_comb begin
    if (!code_err) begin
      // R1
      arith_chk: assert (trit_val(sum_trit) + 3 * trit_val(carry_trit) ==
                         trit_val(a_trit) + trit_val(b_trit) + trit_val(cin_trit))
        else $error("sum/carry do not match operand total");
      // R5
      sum_ind_onehot_chk: assert ($countones(~sum_ind_n) == 1)
        else $error("shared sum indicators not one-hot");
      // R6
      cin2_pair_chk: assert (cry_ind_n[2] || cry_ind_n[3])
        else $error("both cin=2 carry indicators active");
    end else begin
      // R3
      err_zero_chk: assert (sum_trit == T0 && carry_trit == T0)
        else $error("outputs not cleared on illegal code");
    end
    // R2
    legal_code_chk: assert (!trit_bad(sum_trit) && !trit_bad(carry_trit))
      else $error("output carries illegal code");
  end
endmodule

// File: tb/ternary_full_adder_test.sv
module ternary_full_adder_test;
  typedef logic [9:0] vec_t;
  typedef vec_t vec_tab_t [27];

  function automatic logic [1:0] enc(input int v);
    return v[1:0];
  endfunction

  // entry layout: {a, b, cin, sum, carry}
  function automatic vec_tab_t build_tab();
    vec_tab_t t;
    for (int i = 0; i < 27; i++) begin
      int a, b, c, tot;
      a = i / 9; b = (i / 3) % 3; c = i % 3;
      tot = a + b + c;
      t[i] = {enc(a), enc(b), enc(c), enc(tot % 3), enc(tot / 3)};
    end
    return t;
  endfunction

  localparam vec_tab_t VECS = build_tab();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] a, b, cin;
  logic [1:0] sum, carry;
  logic err;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  ternary_full_adder uut (
    .a_trit(a), .b_trit(b), .cin_trit(cin),
    .sum_trit(sum), .carry_trit(carry), .code_err(err)
  );

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d cin=%0d got {err,carry,sum}=%b expected %b",
               req, a, b, cin, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] va, input logic [1:0] vb, input logic [1:0] vc);
    @(posedge clk);
    a = va; b = vb; cin = vc;
    @(negedge clk);
  endtask

  initial begin
    a = 2'b00; b = 2'b00; cin = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R4 reset state: zero inputs give zero outputs and no error
    check("R4", {err, carry, sum}, 5'b0_00_00);
    rst_n = 1'b1;

    // R1 R2 R4 R5 R6 R7 R8: all legal combinations
    for (int i = 0; i < 27; i++) begin
      drive(VECS[i][9:8], VECS[i][7:6], VECS[i][5:4]);
      check("R1/R2/R4/R5/R6/R7/R8", {err, carry, sum}, {1'b0, VECS[i][1:0], VECS[i][3:2]});
    end

    // R8: carry of 2 only for 2+2+2
    drive(2'b10, 2'b10, 2'b10);
    check("R8", {err, carry, sum}, 5'b0_10_00);
    drive(2'b10, 2'b10, 2'b01);
    check("R8", {err, carry, sum}, 5'b0_01_10);

    // R3: illegal code on each input in turn, and on all
    drive(2'b11, 2'b10, 2'b10);
    check("R3", {err, carry, sum}, 5'b1_00_00);
    drive(2'b01, 2'b11, 2'b01);
    check("R3", {err, carry, sum}, 5'b1_00_00);
    drive(2'b10, 2'b01, 2'b11);
    check("R3", {err, carry, sum}, 5'b1_00_00);
    drive(2'b11, 2'b11, 2'b11);
    check("R3", {err, carry, sum}, 5'b1_00_00);

    // R9: operand swap gives identical results
    for (int x = 0; x < 3; x++) begin
      for (int y = 0; y < 3; y++) begin
        for (int c = 0; c < 3; c++) begin
          logic [4:0] first;
          drive(enc(x), enc(y), enc(c));
          first = {err, carry, sum};
          drive(enc(y), enc(x), enc(c));
          check("R9", {err, carry, sum}, first);
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule